// File: doc/BRIEF.md
# Floating-Point Multiple-Register Transfer Sequencer

This block moves any subset of an eight-entry bank of 96-bit floating-point registers to or from memory. Software or a decode stage gives it an extension word, a flag that says whether the addressing mode is predecrement, and a starting word address, then pulses `start_i`. The sequencer walks the selected registers in the required order. For each one it issues three 32-bit word transfers over a valid/ready memory port. At the end it pulses `done_o`, together with `fault_o` if a transfer faulted. It computes no effective address beyond stepping the word address, and it does no rounding or format conversion: the bits move unchanged.

The register list can be static, taken from the extension word itself, or dynamic, taken from the low byte of one of eight integer data registers. Predecrement mode reverses three things: the visiting order, the meaning of the list bits, and the direction in which the address moves.

The controller is a five-state machine:
- IDLE waits for a start.
- SCAN looks at the list bit of the current register and skips it in one cycle if it is clear.
- XFER presents one word at a time until the memory port accepts all three.
- COMMIT writes an assembled register back to the bank on loads.
- FINISH pulses `done_o`.

Its transitions are:
- IDLE→SCAN on a start with a non-empty list.
- IDLE→FINISH on a start with an empty list.
- SCAN→SCAN on a clear list bit.
- SCAN→XFER on a set list bit.
- XFER→COMMIT after the third word of a load.
- XFER→SCAN after the third word of a store when selected registers remain.
- XFER→FINISH after the last store word, or on a fault.
- COMMIT→SCAN when selected registers remain.
- COMMIT→FINISH when none remain.
- FINISH→IDLE always.

Top module: `fp_multi_xfer`

## Requirements
- R1: Extension word bit 13 selects the direction. When it is 1, registers are written to memory (`mem_we_o`=1 on every request and the bank is never written). When it is 0, memory is read into registers.
- R2: When extension word bit 11 is 1, the register list is byte number N of `int_lists_i` (bits 8N+7:8N), where N is extension word bits 6:4. When bit 11 is 0, the list is extension word bits 7:0.
- R3: In predecrement mode (`predec_i`=1) registers are visited from 7 down to 0. Otherwise they are visited from 0 up to 7. List bit 7 is tested for the first register visited, bit 6 for the second, and so on, so bit 7 selects register 7 in predecrement mode and register 0 otherwise.
- R4: Each selected register is sent as three 32-bit words, and each accepted word moves the address 4 bytes in the direction of travel.
  - Outside predecrement mode, the first address is `base_addr_i`, the addresses rise, and the words go most significant first (bits 95:64, then 63:32, then 31:0).
  - In predecrement mode, the first address is `base_addr_i`-4, the addresses fall, and the words go least significant first.
- R5: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, direction and write data stay unchanged into the next cycle. A word is accepted in a cycle where both `mem_req_o` and `mem_ready_i` are high.
- R6: On a load, a register is written exactly once, with a one-cycle `fpr_wr_en_o` pulse, after all three of its words are accepted. Its 96-bit value is the three words placed bit-exactly at the positions given in R4.
- R7: A transfer accepted with `mem_fault_i`=1 ends the sequence. In the next cycle `done_o` and `fault_o` are high and no further request is made.
  - Registers after the faulting one are not touched.
  - On a load, the register whose word faulted is not written.
  - On a store, the words accepted before the fault remain written.
- R8: Each unselected register that precedes the last selected one costs one cycle. `done_o` rises in the cycle after the last word of a store is accepted, or in the cycle after the write of a load. With an empty list, `done_o` rises in the cycle after the start is sampled.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the list, the direction, the mode nor the addresses of the transfer in progress.
- R10: `done_o` is a single-cycle pulse after which the block is idle, and `fault_o` is high only together with `done_o`. After reset `busy_o`, `done_o`, `mem_req_o` and `fpr_wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in IDLE |
| ext_word_i | input | 16 | Extension word: direction, list source, data-register select, static list |
| predec_i | input | 1 | Addressing mode is predecrement |
| base_addr_i | input | 32 | Starting byte address |
| int_lists_i | input | 64 | Low bytes of the eight integer data registers |
| fpr_rd_idx_o | output | 3 | Bank read index for stores |
| fpr_rd_data_i | input | 96 | Bank read data |
| fpr_wr_en_o | output | 1 | Bank write strobe for loads |
| fpr_wr_idx_o | output | 3 | Bank write index |
| fpr_wr_data_o | output | 96 | Bank write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_fault_i | input | 1 | Accepted transfer faulted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| fault_o | output | 1 | Sequence ended by a fault (with done) |

## Verification
The bench builds the block with its defaults: eight registers, three 32-bit words per register, and 32-bit addresses. These are small enough to sweep every one of the 256 static lists in both directions and both addressing modes. Some runs use back-pressure on the memory port. The runs without back-pressure also check the exact cycle count, which brings the skip cost and the timing of `done_o` into reach. A fault is placed on every one of the 24 word positions of a full list, in all four direction and mode combinations. Separate runs cover all eight dynamic list sources and a start pulse that arrives mid-sequence.

// File: rtl/fpmx_pkg.sv
package fpmx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_XFER,
        ST_COMMIT,
        ST_FINISH
    } fpmx_state_e;

endpackage

// File: rtl/fpmx_list_sel.sv
module fpmx_list_sel #(
    parameter int REG_CNT = 8,
    parameter int INT_CNT = 8,
    localparam int SEL_W  = $clog2(INT_CNT)
) (
    input  logic                       dyn_i,
    input  logic [SEL_W-1:0]           sel_i,
    input  logic [REG_CNT-1:0]         static_list_i,
    input  logic [INT_CNT*REG_CNT-1:0] int_lists_i,
    output logic [REG_CNT-1:0]         list_o
);

    logic [REG_CNT-1:0] dyn_list;

    always_comb begin
        dyn_list = '0;
        for (int i = 0; i < INT_CNT; i++) begin
            if (sel_i == SEL_W'(i)) begin
                dyn_list = int_lists_i[i*REG_CNT +: REG_CNT];
            end
        end
    end

    assign list_o = dyn_i ? dyn_list : static_list_i;

endmodule

// File: rtl/fpmx_addr_gen.sv
module fpmx_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              predec_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              down_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= predec_i ? (base_i - STEP) : base_i;
        end else if (adv_i) begin
            addr_q <= down_i ? (addr_q - STEP) : (addr_q + STEP);
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/fpmx_word_unit.sv
module fpmx_word_unit #(
    parameter int WORD_W        = 32,
    parameter int WORDS_PER_REG = 3,
    localparam int REG_W        = WORD_W * WORDS_PER_REG,
    localparam int WIDX_W       = $clog2(WORDS_PER_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsw_first_i,
    input  logic [WIDX_W-1:0] word_i,
    input  logic [REG_W-1:0]  src_reg_i,
    output logic [WORD_W-1:0] src_word_o,
    input  logic              cap_i,
    input  logic [WORD_W-1:0] cap_word_i,
    output logic [REG_W-1:0]  asm_reg_o
);

    logic [WIDX_W-1:0] chunk;
    logic [REG_W-1:0]  asm_q;

    assign chunk = lsw_first_i ? word_i : (WIDX_W'(WORDS_PER_REG - 1) - word_i);

    always_comb begin
        src_word_o = '0;
        for (int c = 0; c < WORDS_PER_REG; c++) begin
            if (chunk == WIDX_W'(c)) begin
                src_word_o = src_reg_i[c*WORD_W +: WORD_W];
            end
        end
    end

    generate
        for (genvar g = 0; g < WORDS_PER_REG; g++) begin : g_chunk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    asm_q[g*WORD_W +: WORD_W] <= '0;
                end else if (cap_i && chunk == WIDX_W'(g)) begin
                    asm_q[g*WORD_W +: WORD_W] <= cap_word_i;
                end
            end
        end
    endgenerate

    assign asm_reg_o = asm_q;

endmodule

// File: rtl/fp_multi_xfer.sv
module fp_multi_xfer
    import fpmx_pkg::*;
#(
    parameter int REG_CNT       = 8,
    parameter int INT_CNT       = 8,
    parameter int WORD_W        = 32,
    parameter int WORDS_PER_REG = 3,
    parameter int ADDR_W        = 32,
    localparam int REG_W        = WORD_W * WORDS_PER_REG,
    localparam int IDX_W        = $clog2(REG_CNT),
    localparam int WIDX_W       = $clog2(WORDS_PER_REG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [15:0]                ext_word_i,
    input  logic                       predec_i,
    input  logic [ADDR_W-1:0]          base_addr_i,
    input  logic [INT_CNT*REG_CNT-1:0] int_lists_i,
    output logic [IDX_W-1:0]           fpr_rd_idx_o,
    input  logic [REG_W-1:0]           fpr_rd_data_i,
    output logic                       fpr_wr_en_o,
    output logic [IDX_W-1:0]           fpr_wr_idx_o,
    output logic [REG_W-1:0]           fpr_wr_data_o,
    output logic                       mem_req_o,
    output logic                       mem_we_o,
    output logic [ADDR_W-1:0]          mem_addr_o,
    output logic [WORD_W-1:0]          mem_wdata_o,
    input  logic                       mem_ready_i,
    input  logic [WORD_W-1:0]          mem_rdata_i,
    input  logic                       mem_fault_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       fault_o
);

    fpmx_state_e state_q, state_d;

    logic [REG_CNT-1:0] list_w;
    logic [REG_CNT-1:0] mask_q;
    logic [IDX_W-1:0]   step_q;
    logic [WIDX_W-1:0]  word_q;
    logic               store_q;
    logic               predec_q;
    logic               fault_q;
    logic [IDX_W-1:0]   reg_idx;
    logic               kick;
    logic               accept_ok;
    logic               accept_bad;
    logic               last_word;
    logic               rest_empty;
    logic               unused_ext;

    assign unused_ext = ^{ext_word_i[15:14], ext_word_i[12], ext_word_i[10:8]};

    fpmx_list_sel #(
        .REG_CNT (REG_CNT),
        .INT_CNT (INT_CNT)
    ) u_list (
        .dyn_i         (ext_word_i[11]),
        .sel_i         (ext_word_i[6:4]),
        .static_list_i (ext_word_i[REG_CNT-1:0]),
        .int_lists_i   (int_lists_i),
        .list_o        (list_w)
    );

    assign kick       = (state_q == ST_IDLE) && start_i;
    assign accept_ok  = (state_q == ST_XFER) && mem_ready_i && !mem_fault_i;
    assign accept_bad = (state_q == ST_XFER) && mem_ready_i && mem_fault_i;
    assign last_word  = (word_q == WIDX_W'(WORDS_PER_REG - 1));
    assign rest_empty = (mask_q[REG_CNT-2:0] == '0);
    assign reg_idx    = predec_q ? (IDX_W'(REG_CNT - 1) - step_q) : step_q;

    fpmx_addr_gen #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (kick),
        .predec_i (predec_i),
        .base_i   (base_addr_i),
        .down_i   (predec_q),
        .adv_i    (accept_ok),
        .addr_o   (mem_addr_o)
    );

    fpmx_word_unit #(
        .WORD_W        (WORD_W),
        .WORDS_PER_REG (WORDS_PER_REG)
    ) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .lsw_first_i (predec_q),
        .word_i      (word_q),
        .src_reg_i   (fpr_rd_data_i),
        .src_word_o  (mem_wdata_o),
        .cap_i       (accept_ok && !store_q),
        .cap_word_i  (mem_rdata_i),
        .asm_reg_o   (fpr_wr_data_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (list_w == '0) ? ST_FINISH : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (mask_q[REG_CNT-1]) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (accept_bad) begin
                    state_d = ST_FINISH;
                end else if (accept_ok && last_word) begin
                    if (!store_q) begin
                        state_d = ST_COMMIT;
                    end else begin
                        state_d = rest_empty ? ST_FINISH : ST_SCAN;
                    end
                end
            end
            ST_COMMIT: state_d = rest_empty ? ST_FINISH : ST_SCAN;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sequence bookkeeping: list, position, word counter, latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            step_q   <= '0;
            word_q   <= '0;
            store_q  <= 1'b0;
            predec_q <= 1'b0;
            fault_q  <= 1'b0;
        end else if (kick) begin
            mask_q   <= list_w;
            step_q   <= '0;
            word_q   <= '0;
            store_q  <= ext_word_i[13];
            predec_q <= predec_i;
            fault_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    if (!mask_q[REG_CNT-1]) begin
                        mask_q <= {mask_q[REG_CNT-2:0], 1'b0};
                        step_q <= step_q + IDX_W'(1);
                    end
                end
                ST_XFER: begin
                    if (accept_bad) begin
                        fault_q <= 1'b1;
                    end else if (accept_ok) begin
                        if (last_word) begin
                            word_q <= '0;
                            if (store_q) begin
                                mask_q <= {mask_q[REG_CNT-2:0], 1'b0};
                                step_q <= step_q + IDX_W'(1);
                            end
                        end else begin
                            word_q <= word_q + WIDX_W'(1);
                        end
                    end
                end
                ST_COMMIT: begin
                    mask_q <= {mask_q[REG_CNT-2:0], 1'b0};
                    step_q <= step_q + IDX_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        mem_req_o    = (state_q == ST_XFER);
        mem_we_o     = (state_q == ST_XFER) && store_q;
        fpr_wr_en_o  = (state_q == ST_COMMIT);
        fpr_rd_idx_o = reg_idx;
        fpr_wr_idx_o = reg_idx;
        done_o       = (state_q == ST_FINISH);
        fault_o      = (state_q == ST_FINISH) && fault_q;
    end

endmodule

// File: rtl/fpmx_checker.sv
module fpmx_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              mem_fault_i,
    input logic              fpr_wr_en_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fault_o,
    input logic              store_q,
    input logic              predec_q
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    p_no_bank_write_on_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_wr_en_o |-> !store_q);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o && mem_ready_i && !mem_fault_i)) |->
        (mem_addr_o == (predec_q ? $past(mem_addr_o) - STEP : $past(mem_addr_o) + STEP)));

    p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    p_write_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_wr_en_o |=> !fpr_wr_en_o);

    p_fault_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && mem_fault_i) |=> (done_o && fault_o && !mem_req_o));

    p_start_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(store_q) && $stable(predec_q)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_fault_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o);

endmodule

bind fp_multi_xfer fpmx_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_fpmx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .mem_fault_i (mem_fault_i),
    .fpr_wr_en_o (fpr_wr_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .store_q     (store_q),
    .predec_q    (predec_q)
);

// File: tb/fp_multi_xfer_bench.sv
module fp_multi_xfer_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ext_w = '0;
    logic        predec = 1'b0;
    logic [31:0] base_addr = BASE;
    logic [63:0] int_lists = 64'h3C_A5_81_7E_0F_F0_55_12;
    logic [2:0]  rd_idx, wr_idx;
    logic [95:0] rd_data, wr_data;
    logic        wr_en, mem_req, mem_we, mem_ready, mem_fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, fault;

    logic [31:0] mem [0:255];
    logic [95:0] bank [0:7];
    logic [31:0] exp_mem [0:255];
    logic [95:0] exp_bank [0:7];

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int hs_cnt = 0;
    int fault_at = -1;
    bit stall = 1'b0;
    int seed = 1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp_multi_xfer u_fp_multi_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .ext_word_i    (ext_w),
        .predec_i      (predec),
        .base_addr_i   (base_addr),
        .int_lists_i   (int_lists),
        .fpr_rd_idx_o  (rd_idx),
        .fpr_rd_data_i (rd_data),
        .fpr_wr_en_o   (wr_en),
        .fpr_wr_idx_o  (wr_idx),
        .fpr_wr_data_o (wr_data),
        .mem_req_o     (mem_req),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .mem_ready_i   (mem_ready),
        .mem_rdata_i   (mem_rdata),
        .mem_fault_i   (mem_fault),
        .busy_o        (busy),
        .done_o        (done),
        .fault_o       (fault)
    );

    assign rd_data = bank[rd_idx];

    // Memory responder: drives inputs at the falling edge
    always @(negedge clk) begin
        mem_ready = mem_req && (!stall || (cycles % 3 != 1));
        mem_rdata = mem[mem_addr[9:2]];
        mem_fault = mem_req && mem_ready && (hs_cnt == fault_at);
    end

    // Memory and bank models commit at the rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && mem_ready) begin
            hs_cnt <= hs_cnt + 1;
            if (!mem_fault && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
        if (wr_en) bank[wr_idx] <= wr_data;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] ext, input logic pd, input int fat,
                       input bit stl, input bit glitch);
        logic [7:0]  list;
        logic [31:0] p;
        logic [95:0] tmp;
        int n = 0, lastpos = 0, nhs = 0, k = 0, cexp, bad_m = 0, bad_b = 0;
        bit aborted = 0, st;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203) ^ (seed * 32'h0707_0000);
        for (int r = 0; r < 8; r++) bank[r] = {32'hB000_0000 + r, 32'hC100_0000 ^ seed, 32'hD200_0000 + r * 17 + seed};
        seed++;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int r = 0; r < 8; r++) exp_bank[r] = bank[r];
        // expected result from the requirements
        list = ext[11] ? int_lists[ext[6:4]*8 +: 8] : ext[7:0];
        st = ext[13];
        p = pd ? BASE - 4 : BASE;
        for (int s = 0; s < 8 && !aborted; s++) begin
            int r = pd ? 7 - s : s;
            if (list[7 - s]) begin
                tmp = bank[r];
                for (int w = 0; w < 3 && !aborted; w++) begin
                    int c = pd ? w : 2 - w;
                    if (nhs == fat) begin
                        aborted = 1;
                    end else begin
                        if (st) exp_mem[p[9:2]] = bank[r][c*32 +: 32];
                        else tmp[c*32 +: 32] = mem[p[9:2]];
                        p = pd ? p - 4 : p + 4;
                    end
                    nhs++;
                end
                if (!aborted && !st) exp_bank[r] = tmp;
                n++;
                lastpos = s + 1;
            end
        end
        cexp = lastpos + n * (st ? 3 : 4);
        hs_cnt = 0;
        fault_at = fat;
        stall = stl;
        start = 1'b1;
        ext_w = ext;
        predec = pd;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && k < 400) begin
            if (glitch && k == 2) begin
                start = 1'b1;
                ext_w = ext ^ 16'h20FF;
                predec = !pd;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(done, "R10", "done reached", longint'(done), 1);
        chk(fault == aborted, "R7", "fault flag", longint'(fault), longint'(aborted));
        chk(hs_cnt == (aborted ? fat + 1 : n * 3), "R4", "accepted words",
            hs_cnt, aborted ? fat + 1 : n * 3);
        if (!stl && fat < 0 && !glitch)
            chk(k == cexp, "R8", "cycles to done", k, cexp);
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R10", "done single pulse", longint'(done), 0);
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad_m++;
        for (int r = 0; r < 8; r++) if (bank[r] !== exp_bank[r]) bad_b++;
        chk(bad_m == 0, st ? "R3" : "R1", "memory mismatches", bad_m, 0);
        chk(bad_b == 0, st ? "R1" : "R6", "bank mismatches", bad_b, 0);
        if (glitch) chk(bad_m == 0 && bad_b == 0, "R9", "busy start ignored", bad_m + bad_b, 0);
        if (ext[11]) chk(bad_m == 0 && bad_b == 0, "R2", "dynamic list", bad_m + bad_b, 0);
        if (fat >= 0) chk(bad_m == 0 && bad_b == 0, "R7", "aborted state", bad_m + bad_b, 0);
        if (stl) chk(bad_m == 0 && bad_b == 0, "R5", "under back-pressure", bad_m + bad_b, 0);
    endtask

    initial begin
        mem_ready = 1'b0;
        mem_fault = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !wr_en, "R10", "reset state",
            {busy, done, mem_req, wr_en}, 0);
        // R8: empty list, done one cycle after start, both directions
        run(16'h2000, 1'b0, -1, 1'b0, 1'b0);
        run(16'h0000, 1'b1, -1, 1'b0, 1'b0);
        // Static lists: full sweep over list, direction and mode (R1 R3 R4 R6 R8)
        for (int l = 0; l < 256; l++) begin
            for (int d = 0; d < 2; d++) begin
                for (int m = 0; m < 2; m++) begin
                    run({2'b00, d[0], 5'b0, l[7:0]}, m[0], -1, (l % 3) == 1, 1'b0);
                end
            end
        end
        // R2: dynamic list source from every integer register
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                run({2'b00, d[0], 1'b0, 1'b1, 4'b0, s[2:0], 4'hB}, s[0], -1, 1'b0, 1'b0);
            end
        end
        // R7: a fault at every word of a full list
        for (int f = 0; f < 24; f++) begin
            for (int d = 0; d < 2; d++) begin
                for (int m = 0; m < 2; m++) begin
                    run({2'b00, d[0], 5'b0, 8'hFF}, m[0], f, f[0], 1'b0);
                end
            end
        end
        // R9: start pulse while busy
        run(16'h20FF, 1'b0, -1, 1'b0, 1'b1);
        run(16'h00A5, 1'b1, -1, 1'b1, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule